// File: doc/BRIEF.md
# Bus Address Decoder with Built-in Default Slave

This block sits between one bus master and a set of slaves on a pipelined on-chip bus that follows the AHB protocol. In every cycle it compares the upper bits of the master's address against a table of slave regions and raises the select line of the matching slave. The table is set by parameters as a base and a mask per slave, counted in 1 KB pages. At the end of each address phase in which the bus is ready, it records which slave was addressed. During the following data phase, that record steers read data, ready and response from that slave back to the master.

An address that hits no region goes to a small slave inside the block. For IDLE and BUSY transfers this default slave answers OKAY with no wait state. For NONSEQ and SEQ transfers it answers ERROR, using the two-cycle sequence. Read data from the default slave is zero. The bus ready output is meant to be fed back as the ready input of every slave and of this block.

Top module: `ahb_region_decode`

## Requirements
- R1: A slave's select is high when address bits 31..10, masked by that slave's region mask, equal its region base; bits 9..0 never affect the select. At most one select is high, and the lowest index wins on overlap. With default parameters the regions are slave 0 at 0x0000–0x0FFF, slave 1 at 0x1000–0x1FFF, slave 2 at 0x2000–0x2FFF and slave 3 at 0x10000–0x103FF.
- R2: An address outside every region leaves all select lines low and addresses the default slave.
- R3: The data-phase selection (slave index or default) is captured only at a clock edge where the ready input is high. While ready is low it holds, whatever the address and transfer type do.
- R4: While a real slave owns the data phase, read data, ready and response outputs equal that slave's inputs.
- R5: A NONSEQ (10) or SEQ (11) transfer to an unmapped address gets ERROR (response code 01) over two cycles. In the first, ready is low. In the second, ready is high and the response is still ERROR.
- R6: An IDLE (00) or BUSY (01) transfer to an unmapped address gets OKAY (00) with ready high in the very next cycle.
- R7: During and after reset, until the first captured address phase, the default slave owns the data phase. Ready is high, the response is OKAY (00) and read data is zero. Read data is also zero whenever the default slave owns the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| haddr_i | input | AW | Master address |
| htrans_i | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hready_i | input | 1 | Bus ready, normally the looped-back hready_o |
| slv_rdata_i | input | N_SLV*DW | Read data of each slave, slave i at bits [i*DW +: DW] |
| slv_ready_i | input | N_SLV | Ready output of each slave |
| slv_resp_i | input | N_SLV*2 | Response of each slave, slave i at bits [2i +: 2] |
| hsel_o | output | N_SLV | Select line of each slave |
| hrdata_o | output | DW | Read data to the master |
| hready_o | output | 1 | Ready to the master and to all slaves |
| hresp_o | output | 2 | Response to the master: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT |

## Verification
Suppose the captured selection is wrong, for example updated during a stall or pointing at the wrong slave. Then, in the first data-phase cycle after the edge, read data, ready or response comes from the wrong source. A reference model that checks every cycle catches this on that cycle. A default slave stuck in the wrong state shows on the ready or response output in the cycle right after the unmapped address phase: the ERROR sequence is missing, has one cycle too few or too many, or an OKAY was never given. Select errors are combinational, so they show in the same cycle the address is driven. The bench probes the region edges by hitting addresses just inside and just outside them.

// File: rtl/ahb_rdec_pkg.sv
package ahb_rdec_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY  = 2'b00,
    RESP_ERROR = 2'b01,
    RESP_RETRY = 2'b10,
    RESP_SPLIT = 2'b11
  } resp_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  localparam int unsigned PAGE_LSB = 10;
endpackage

// File: rtl/rdec_region_match.sv
module rdec_region_match
  import ahb_rdec_pkg::*;
#(
  parameter int unsigned N_SLV = 4,
  parameter int unsigned AW    = 32,
  parameter int unsigned PW    = AW - PAGE_LSB,
  parameter int unsigned IW    = (N_SLV > 1) ? $clog2(N_SLV) : 1,
  parameter logic [N_SLV*PW-1:0] BASE = '0,
  parameter logic [N_SLV*PW-1:0] MASK = '1
) (
  input  logic [AW-1:0]    addr_i,
  output logic [N_SLV-1:0] hit_o,
  output logic             any_o,
  output logic [IW-1:0]    idx_o
);
  logic [N_SLV-1:0] raw;
  logic [PW-1:0]    page;

  assign page = addr_i[AW-1:PAGE_LSB];

  for (genvar g = 0; g < N_SLV; g++) begin : g_cmp
    assign raw[g] = ((page & MASK[g*PW +: PW]) == BASE[g*PW +: PW]);
  end

  // lowest index wins on overlap
  assign hit_o = raw & (~raw + N_SLV'(1));
  assign any_o = |raw;

  always_comb begin
    idx_o = '0;
    for (int i = N_SLV - 1; i >= 0; i--) begin
      if (raw[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/rdec_dphase_sel.sv
module rdec_dphase_sel #(
  parameter int unsigned IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hready_i,
  input  logic          any_i,
  input  logic [IW-1:0] idx_i,
  output logic          dflt_q_o,
  output logic [IW-1:0] idx_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dflt_q_o <= 1'b1;
      idx_q_o  <= '0;
    end else if (hready_i) begin
      dflt_q_o <= ~any_i;
      idx_q_o  <= idx_i;
    end
  end

  a_r3_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_i |=> ($stable(dflt_q_o) && $stable(idx_q_o)));
endmodule

// File: rtl/rdec_default_slave.sv
module rdec_default_slave
  import ahb_rdec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hready_i,
  input  logic       any_i,
  input  logic [1:0] htrans_i,
  output logic       ready_o,
  output logic [1:0] resp_o
);
  typedef enum logic [1:0] {DS_OK, DS_ERR_A, DS_ERR_B} ds_e;
  ds_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (st_q == DS_ERR_A) st_d = DS_ERR_B;
    else if (hready_i) st_d = (!any_i && htrans_i[1]) ? DS_ERR_A : DS_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= DS_OK;
    else         st_q <= st_d;
  end

  assign ready_o = (st_q != DS_ERR_A);
  assign resp_o  = (st_q == DS_OK) ? RESP_OKAY : RESP_ERROR;

  a_r5_err_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o) |=> (ready_o && resp_o == RESP_ERROR));
endmodule

// File: rtl/rdec_resp_mux.sv
module rdec_resp_mux #(
  parameter int unsigned N_SLV = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned IW    = 2
) (
  input  logic                dflt_i,
  input  logic [IW-1:0]       idx_i,
  input  logic [N_SLV*DW-1:0] slv_rdata_i,
  input  logic [N_SLV-1:0]    slv_ready_i,
  input  logic [N_SLV*2-1:0]  slv_resp_i,
  input  logic                ds_ready_i,
  input  logic [1:0]          ds_resp_i,
  output logic [DW-1:0]       rdata_o,
  output logic                ready_o,
  output logic [1:0]          resp_o
);
  logic [DW-1:0] rd_arr [N_SLV];
  logic [1:0]    rs_arr [N_SLV];

  for (genvar g = 0; g < N_SLV; g++) begin : g_unpack
    assign rd_arr[g] = slv_rdata_i[g*DW +: DW];
    assign rs_arr[g] = slv_resp_i[g*2 +: 2];
  end

  always_comb begin
    if (dflt_i) begin
      rdata_o = '0;
      ready_o = ds_ready_i;
      resp_o  = ds_resp_i;
    end else begin
      rdata_o = rd_arr[idx_i];
      ready_o = slv_ready_i[idx_i];
      resp_o  = rs_arr[idx_i];
    end
  end
endmodule

// File: rtl/ahb_region_decode.sv
module ahb_region_decode
  import ahb_rdec_pkg::*;
#(
  parameter int unsigned N_SLV = 4,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter logic [N_SLV*(AW-10)-1:0] REGION_BASE =
    {22'h000040, 22'h000008, 22'h000004, 22'h000000},
  parameter logic [N_SLV*(AW-10)-1:0] REGION_MASK =
    {22'h3FFFFF, 22'h3FFFFC, 22'h3FFFFC, 22'h3FFFFC}
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       haddr_i,
  input  logic [1:0]          htrans_i,
  input  logic                hready_i,
  input  logic [N_SLV*DW-1:0] slv_rdata_i,
  input  logic [N_SLV-1:0]    slv_ready_i,
  input  logic [N_SLV*2-1:0]  slv_resp_i,
  output logic [N_SLV-1:0]    hsel_o,
  output logic [DW-1:0]       hrdata_o,
  output logic                hready_o,
  output logic [1:0]          hresp_o
);
  localparam int unsigned PW = AW - PAGE_LSB;
  localparam int unsigned IW = (N_SLV > 1) ? $clog2(N_SLV) : 1;

  logic          any_hit;
  logic [IW-1:0] hit_idx;
  logic          dflt_q;
  logic [IW-1:0] idx_q;
  logic          ds_ready;
  logic [1:0]    ds_resp;

  rdec_region_match #(
    .N_SLV(N_SLV), .AW(AW), .PW(PW), .IW(IW),
    .BASE(REGION_BASE), .MASK(REGION_MASK)
  ) u_match (
    .addr_i(haddr_i), .hit_o(hsel_o), .any_o(any_hit), .idx_o(hit_idx)
  );

  rdec_dphase_sel #(.IW(IW)) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .hready_i(hready_i),
    .any_i(any_hit), .idx_i(hit_idx), .dflt_q_o(dflt_q), .idx_q_o(idx_q)
  );

  rdec_default_slave u_dflt (
    .clk_i(clk_i), .rst_ni(rst_ni), .hready_i(hready_i), .any_i(any_hit),
    .htrans_i(htrans_i), .ready_o(ds_ready), .resp_o(ds_resp)
  );

  rdec_resp_mux #(.N_SLV(N_SLV), .DW(DW), .IW(IW)) u_mux (
    .dflt_i(dflt_q), .idx_i(idx_q), .slv_rdata_i(slv_rdata_i),
    .slv_ready_i(slv_ready_i), .slv_resp_i(slv_resp_i),
    .ds_ready_i(ds_ready), .ds_resp_i(ds_resp),
    .rdata_o(hrdata_o), .ready_o(hready_o), .resp_o(hresp_o)
  );

  always_comb begin
    a_r1_sel_onehot0: assert ($onehot0(hsel_o));
  end

  a_r5_err_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && hsel_o == '0 && htrans_i[1])
      |=> (!hready_o && hresp_o == RESP_ERROR && hrdata_o == '0));

  a_r6_idle_okay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && hsel_o == '0 && !htrans_i[1])
      |=> (hready_o && hresp_o == RESP_OKAY));

  a_r4_slave_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && hsel_o != '0) |=> (hresp_o != RESP_ERROR || hready_o || slv_ready_i != '1));
endmodule

// File: tb/tb_ahb_region_decode.sv
module tb_ahb_region_decode;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [31:0]     haddr = '0;
  logic [1:0]      htrans = 2'b00;
  logic            hready_in;
  logic [N*DW-1:0] slv_rdata = '0;
  logic [N-1:0]    slv_ready = '1;
  logic [N*2-1:0]  slv_resp = '0;
  logic [N-1:0]    hsel;
  logic [DW-1:0]   hrdata;
  logic            hready;
  logic [1:0]      hresp;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int m_sel = -1;
  int m_err = 0;
  bit prev_stall = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign hready_in = hready;

  ahb_region_decode dut (
    .clk_i(clk), .rst_ni(rst_n), .haddr_i(haddr), .htrans_i(htrans),
    .hready_i(hready_in), .slv_rdata_i(slv_rdata), .slv_ready_i(slv_ready),
    .slv_resp_i(slv_resp), .hsel_o(hsel), .hrdata_o(hrdata),
    .hready_o(hready), .hresp_o(hresp)
  );

  function automatic int dec(input logic [31:0] a);
    if (a < 32'h1000) return 0;
    if (a < 32'h2000) return 1;
    if (a < 32'h3000) return 2;
    if (a >= 32'h10000 && a < 32'h10400) return 3;
    return -1;
  endfunction

  function automatic bit exp_ready();
    if (m_sel < 0) return (m_err != 1);
    return slv_ready[m_sel];
  endfunction

  function automatic logic [1:0] exp_resp();
    if (m_sel < 0) return (m_err == 0) ? 2'b00 : 2'b01;
    return slv_resp[m_sel*2 +: 2];
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (m_sel < 0) return '0;
    return slv_rdata[m_sel*DW +: DW];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = -1; m_err = 0; prev_stall = 0;
    end else begin
      automatic bit r = exp_ready();
      automatic int d = dec(haddr);
      if (m_err == 1) m_err = 2;
      else if (r) m_err = (d < 0 && htrans[1]) ? 1 : 0;
      if (r) m_sel = d;
      prev_stall = !r;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string force_tag);
    automatic int d = dec(haddr);
    automatic string st, dt;
    st = (d >= 0) ? "R1" : "R2";
    if (force_tag != "") dt = force_tag;
    else if (prev_stall) dt = "R3";
    else if (m_sel >= 0) dt = "R4";
    else if (m_err != 0) dt = "R5";
    else dt = "R6";
    chk(st, "hsel", 64'(hsel), (d < 0) ? 64'd0 : (64'd1 << d));
    chk(dt, "hready", 64'(hready), 64'(exp_ready()));
    chk(dt, "hresp", 64'(hresp), 64'(exp_resp()));
    chk((m_sel < 0) ? "R7" : dt, "hrdata", 64'(hrdata), 64'(exp_rdata()));
  endtask

  task automatic step(input logic [31:0] a, input logic [1:0] t, input string tag);
    haddr = a; htrans = t;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    haddr = 32'h5000; htrans = 2'b00;
    slv_rdata = {32'hDDDD0003, 32'hCCCC0002, 32'hBBBB0001, 32'hAAAA0000};
    repeat (3) @(negedge clk);
    // R7: reset state while held in reset
    chk("R7", "hready in reset", 64'(hready), 64'd1);
    chk("R7", "hresp in reset", 64'(hresp), 64'd0);
    chk("R7", "hrdata in reset", 64'(hrdata), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R7");
    // R1: low address bits ignored, region edges
    step(32'h0000_03FF, 2'b10, "");
    step(32'h0000_0FFC, 2'b11, "");
    step(32'h0000_1000, 2'b10, "");
    step(32'h0000_2FFF, 2'b10, "");
    step(32'h0001_03FF, 2'b10, "");
    // R5: unmapped NONSEQ, then master keeps driving during stall
    step(32'h0001_0400, 2'b10, "");
    step(32'h0000_3000, 2'b11, "R5");
    step(32'h0000_0000, 2'b00, "R5");
    // R6: unmapped IDLE and BUSY
    step(32'h0000_3000, 2'b00, "");
    step(32'h8000_0000, 2'b01, "");
    step(32'h0000_1004, 2'b10, "");
    // back-to-back unmapped SEQ
    step(32'hFFFF_FFFC, 2'b11, "");
    step(32'hFFFF_FFFC, 2'b11, "");
    step(32'hFFFF_FFFC, 2'b11, "");
    step(32'h0000_0000, 2'b00, "");
    // random phase with slave stalls (R3, R4)
    for (int k = 0; k < 4000; k++) begin
      automatic int pick = $urandom_range(0, 7);
      automatic logic [31:0] a;
      case (pick)
        0: a = $urandom_range(0, 32'h0FFF);
        1: a = 32'h1000 + $urandom_range(0, 32'h0FFF);
        2: a = 32'h2000 + $urandom_range(0, 32'h0FFF);
        3: a = 32'h10000 + $urandom_range(0, 32'h3FF);
        4: a = 32'h10400 + $urandom_range(0, 32'h3FF);
        5: a = 32'h3000 + $urandom_range(0, 32'h0FFF);
        default: a = $urandom;
      endcase
      for (int s = 0; s < N; s++) begin
        slv_ready[s] = ($urandom_range(0, 3) != 0);
        slv_resp[s*2 +: 2] = 2'($urandom_range(0, 1));
        slv_rdata[s*DW +: DW] = $urandom;
      end
      step(a, 2'($urandom_range(0, 3)), "");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule